// File: doc/BRIEF.md
# Debug Session State Sequencer

This block tracks the progress of a debug session through a short chain of trigger stages. Software arms the session, which places the sequencer in the first active stage. Match events from external comparators then move it forward through the second and third active stages, or send it straight to a terminal stage. The current stage is always visible as a 3-bit status code. Software cannot write this code. It changes only when the session advances, starts or ends.

A session can end in two ways. If software disarms it, the status code keeps the stage that was reached, so the debugger can see how far the session got. If an internal end event occurs, the status code goes back to the idle code. Reaching the terminal stage raises that internal end event by itself, one cycle later.

Top module: `seq_dbg_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block goes to `flags` = 000 and `armed` = 0.
- R2: `arm_wr` high at an edge sets `flags` = 001 and `armed` = 1 after that edge. This holds from any stage, including while already armed, and `arm_wr` takes priority over every other input in the same cycle.
- R3: While armed in active stage n, only `match_evt` bit n-1 is looked at (stage1 = 001, stage2 = 010, stage3 = 011). When that bit is high, the sequencer moves to the terminal stage (100) if `tgt_final` bit n-1 is 1 or n is 3. Otherwise it moves to stage n+1. The match bits of the other stages have no effect.
- R4: The terminal code 100 appears for exactly one cycle. At the next edge the sequencer goes to `flags` = 000 and `armed` = 0, unless `arm_wr` is high.
- R5: `disarm_wr` while armed, with no end event and no arm, clears `armed` and keeps `flags` unchanged. A match in the same cycle is ignored.
- R6: `end_evt` while armed, with no arm, sets `flags` = 000 and `armed` = 0. It takes priority over `disarm_wr` in the same cycle.
- R7: While disarmed, `match_evt`, `tgt_final`, `end_evt` and `disarm_wr` leave `flags` and `armed` unchanged.
- R8: The codes 101, 110 and 111 never appear on `flags`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_wr | input | 1 | Software arm strobe |
| disarm_wr | input | 1 | Software disarm strobe |
| match_evt | input | 3 | Match event, one bit per active stage (bit0 = stage1) |
| tgt_final | input | 3 | Per-stage target select: 1 jumps to the terminal stage |
| end_evt | input | 1 | Internal end-of-session event |
| flags | output | 3 | Current stage code |
| armed | output | 1 | Session active |

## Verification
The key collision is a software disarm and an internal end arriving in the same cycle. Their rules for the status code conflict: one keeps the code and the other clears it. The bench drives `disarm_wr` and `end_evt` high together in an active stage. It also drives `disarm_wr` in the cycle in which the sequencer sits in the terminal stage. In both cases it expects 000, because the end rule wins. Arm combined with an end event is also provoked, and it must give 001.

// File: rtl/seq_dbg_pkg.sv
// Package: stage codes and sizes shared by the debug sequencer.
// Assumes a 3-bit status code with three active stages.
package seq_dbg_pkg;
    localparam int SEQ_ACTIVE = 3;
    localparam int SEQ_CODE_W = 3;

    typedef enum logic [SEQ_CODE_W-1:0] {
        ST_IDLE  = 3'b000,
        ST_ONE   = 3'b001,
        ST_TWO   = 3'b010,
        ST_THREE = 3'b011,
        ST_FINAL = 3'b100
    } seq_code_t;
endpackage

// File: rtl/seq_dbg_advance.sv
// Module: seq_dbg_advance
// Decides, as pure logic, whether the current active stage sees its own
// match event and which stage comes next. Assumes the code is one of
// the legal stage codes.
module seq_dbg_advance
    import seq_dbg_pkg::*;
(
    input  seq_code_t             cur_code,
    input  logic [SEQ_ACTIVE-1:0] match_evt,
    input  logic [SEQ_ACTIVE-1:0] tgt_final,
    output logic                  adv_hit,
    output seq_code_t             adv_code
);
    logic [SEQ_ACTIVE-1:0] stage_hit;
    logic [SEQ_ACTIVE-1:0] stage_jump;

    // Per-stage qualification: a match counts only in its own stage.
    for (genvar g = 0; g < SEQ_ACTIVE; g++) begin : g_stage
        assign stage_hit[g]  = (cur_code == seq_code_t'(g + 1)) && match_evt[g];
        assign stage_jump[g] = tgt_final[g] || (g == SEQ_ACTIVE - 1);
    end

    // Next-code selection for a qualified match.
    always_comb begin
        adv_hit  = |stage_hit;
        adv_code = cur_code;
        for (int i = 0; i < SEQ_ACTIVE; i++) begin
            if (stage_hit[i]) begin
                adv_code = stage_jump[i] ? ST_FINAL : seq_code_t'(i + 2);
            end
        end
    end
endmodule

// File: rtl/seq_dbg_session.sv
// Module: seq_dbg_session
// Holds the armed bit and the stage register. Applies, in this priority:
// reset, arm, end (external or terminal stage), disarm, match.
// Assumes a synchronous active-low reset.
module seq_dbg_session
    import seq_dbg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      arm_wr,
    input  logic      disarm_wr,
    input  logic      end_evt,
    input  logic      adv_hit,
    input  seq_code_t adv_code,
    output seq_code_t cur_code,
    output logic      armed_q
);
    logic sess_end;

    // Internal end: external event or one cycle spent in the terminal stage.
    always_comb sess_end = armed_q && (end_evt || cur_code == ST_FINAL);

    // Session register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_code <= ST_IDLE;
            armed_q  <= 1'b0;
        end else if (arm_wr) begin
            cur_code <= ST_ONE;
            armed_q  <= 1'b1;
        end else if (sess_end) begin
            cur_code <= ST_IDLE;
            armed_q  <= 1'b0;
        end else if (armed_q && disarm_wr) begin
            armed_q  <= 1'b0;
        end else if (armed_q && adv_hit) begin
            cur_code <= adv_code;
        end
    end
endmodule

// File: rtl/seq_dbg_sequencer.sv
// Module: seq_dbg_sequencer (top)
// Debug session state sequencer: shows the current stage on flags and
// the session state on armed. There is no write path to the flags.
module seq_dbg_sequencer
    import seq_dbg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  arm_wr,
    input  logic                  disarm_wr,
    input  logic [SEQ_ACTIVE-1:0] match_evt,
    input  logic [SEQ_ACTIVE-1:0] tgt_final,
    input  logic                  end_evt,
    output logic [SEQ_CODE_W-1:0] flags,
    output logic                  armed
);
    seq_code_t cur_code;
    seq_code_t adv_code;
    logic      adv_hit;

    seq_dbg_advance u_adv (
        .cur_code (cur_code),
        .match_evt(match_evt),
        .tgt_final(tgt_final),
        .adv_hit  (adv_hit),
        .adv_code (adv_code)
    );

    seq_dbg_session u_sess (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_wr   (arm_wr),
        .disarm_wr(disarm_wr),
        .end_evt  (end_evt),
        .adv_hit  (adv_hit),
        .adv_code (adv_code),
        .cur_code (cur_code),
        .armed_q  (armed)
    );

    // Status output.
    always_comb flags = cur_code;
endmodule

// File: rtl/seq_dbg_checker.sv
// Module: seq_dbg_checker
// Port-level properties of the sequencer, attached with bind.
module seq_dbg_checker
    import seq_dbg_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  arm_wr,
    input logic                  disarm_wr,
    input logic [SEQ_ACTIVE-1:0] match_evt,
    input logic [SEQ_ACTIVE-1:0] tgt_final,
    input logic                  end_evt,
    input logic [SEQ_CODE_W-1:0] flags,
    input logic                  armed
);
    // R8: reserved codes never appear.
    a_r8_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        flags <= 3'b100);

    // R2: arm enters stage one.
    a_r2_arm_entry: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> (flags == 3'b001) && armed);

    // R3: a stage-one match with no jump goes to stage two.
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !arm_wr && !disarm_wr && !end_evt && flags == 3'b001
         && match_evt[0] && !tgt_final[0]) |=> flags == 3'b010);

    // R4: the terminal stage lasts one cycle.
    a_r4_final_once: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 3'b100 && !arm_wr) |=> (flags == 3'b000) && !armed);

    // R5: software disarm keeps the code.
    a_r5_disarm_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && disarm_wr && !arm_wr && !end_evt && flags != 3'b100)
        |=> !armed && flags == $past(flags));

    // R6: an internal end clears the code.
    a_r6_end_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && end_evt && !arm_wr) |=> (flags == 3'b000) && !armed);

    // R7: nothing moves while disarmed except arm.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !arm_wr) |=> !armed && $stable(flags));
endmodule

bind seq_dbg_sequencer seq_dbg_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_wr   (arm_wr),
    .disarm_wr(disarm_wr),
    .match_evt(match_evt),
    .tgt_final(tgt_final),
    .end_evt  (end_evt),
    .flags    (flags),
    .armed    (armed)
);

// File: tb/sim_seq_dbg_sequencer.sv
// Scoreboard bench: the driver computes the expected result of each cycle
// and queues it; the monitor compares it after the clock edge.
module sim_seq_dbg_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm_wr = 1'b0;
    logic       disarm_wr = 1'b0;
    logic [2:0] match_evt = '0;
    logic [2:0] tgt_final = '0;
    logic       end_evt = 1'b0;
    logic [2:0] flags;
    logic       armed;

    typedef struct {
        logic [2:0] f;
        logic       a;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    int         n_cmp = 0;
    int         n_bad = 0;
    logic [2:0] mf = 3'b000;
    logic       ma = 1'b0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    seq_dbg_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .arm_wr(arm_wr), .disarm_wr(disarm_wr),
        .match_evt(match_evt), .tgt_final(tgt_final), .end_evt(end_evt),
        .flags(flags), .armed(armed)
    );

    // Driver: apply one cycle of stimulus and queue the expected result.
    task automatic step(input logic rn, input logic ar, input logic dw,
                        input logic [2:0] m, input logic [2:0] t,
                        input logic ee, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = rn; arm_wr = ar; disarm_wr = dw;
        match_evt = m; tgt_final = t; end_evt = ee;
        if (!rn) begin
            mf = 3'b000; ma = 1'b0;
        end else if (ar) begin
            mf = 3'b001; ma = 1'b1;
        end else if (ma && (ee || mf == 3'b100)) begin
            mf = 3'b000; ma = 1'b0;
        end else if (ma && dw) begin
            ma = 1'b0;
        end else if (ma && mf >= 3'b001 && mf <= 3'b011 && m[mf-1]) begin
            mf = (t[mf-1] || mf == 3'b011) ? 3'b100 : mf + 3'b001;
        end
        e.f = mf; e.a = ma; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare after each edge.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_cmp++;
            if (flags !== e.f || armed !== e.a) begin
                n_bad++;
                $display("FAIL %s: flags=%b armed=%b expected flags=%b armed=%b",
                         e.tag, flags, armed, e.f, e.a);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(0, 0, 0, 3'b000, 3'b000, 0, "R1 reset");
        step(0, 1, 0, 3'b111, 3'b000, 1, "R1 reset over arm");
        // R7: disarmed, everything but arm ignored
        step(1, 0, 0, 3'b111, 3'b111, 0, "R7 match idle");
        step(1, 0, 1, 3'b000, 3'b000, 1, "R7 disarm/end idle");
        // R2 then R3 full walk
        step(1, 1, 0, 3'b000, 3'b000, 0, "R2 arm");
        step(1, 0, 0, 3'b110, 3'b000, 0, "R3 other-stage matches ignored");
        step(1, 0, 0, 3'b001, 3'b000, 0, "R3 stage1 to stage2");
        step(1, 0, 0, 3'b101, 3'b000, 0, "R3 stage2 ignores bits 0,2");
        step(1, 0, 0, 3'b010, 3'b000, 0, "R3 stage2 to stage3");
        step(1, 0, 0, 3'b100, 3'b000, 0, "R3 stage3 to final");
        step(1, 0, 0, 3'b000, 3'b000, 0, "R4 final ends");
        step(1, 0, 0, 3'b000, 3'b000, 0, "R7 idle after end");
        // R3 jump, then R4 against disarm in final
        step(1, 1, 0, 3'b000, 3'b000, 0, "R2 rearm");
        step(1, 0, 0, 3'b001, 3'b001, 0, "R3 stage1 jump final");
        step(1, 0, 1, 3'b000, 3'b000, 0, "R4 final beats disarm");
        // R5 disarm keeps code, ignores match
        step(1, 1, 0, 3'b000, 3'b000, 0, "R2 arm again");
        step(1, 0, 0, 3'b001, 3'b000, 0, "R3 to stage2");
        step(1, 0, 1, 3'b010, 3'b000, 0, "R5 disarm keeps");
        step(1, 0, 0, 3'b010, 3'b000, 1, "R7 held code stays");
        // R6 collision with disarm
        step(1, 1, 0, 3'b000, 3'b000, 0, "R2 arm from held");
        step(1, 0, 0, 3'b001, 3'b010, 0, "R3 stage1 to stage2 tgt other");
        step(1, 0, 1, 3'b000, 3'b000, 1, "R6 end beats disarm");
        step(1, 1, 0, 3'b000, 3'b000, 0, "R2 arm");
        step(1, 0, 0, 3'b000, 3'b000, 1, "R6 end clears stage1");
        // R2 priority and rearm while armed
        step(1, 1, 0, 3'b000, 3'b000, 0, "R2 arm");
        step(1, 0, 0, 3'b001, 3'b000, 0, "R3 to stage2");
        step(1, 1, 0, 3'b010, 3'b000, 0, "R2 rearm while armed");
        step(1, 1, 1, 3'b001, 3'b001, 1, "R2 arm beats all");
        step(1, 0, 0, 3'b001, 3'b000, 0, "R3 to stage2");
        step(1, 0, 0, 3'b010, 3'b010, 0, "R3 stage2 jump final");
        step(1, 1, 0, 3'b000, 3'b000, 0, "R2 arm from final");
        step(1, 0, 0, 3'b000, 3'b000, 0, "R8 legal code hold");
        step(0, 0, 0, 3'b000, 3'b000, 0, "R1 reset while armed");
        step(1, 0, 0, 3'b000, 3'b000, 0, "R1 after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule